// File: doc/BRIEF.md
# Configurable Dual-Output Logic Macrocell

One programmable logic cell. A sum-of-products term enters the cell and can be inverted by a configuration bit. The result is driven straight out as a combinational output. At the same time it can load a storage element whose value drives a second, registered output. The storage element works either as an edge-triggered D flip-flop or as a level-sensitive D latch. A configuration bit can switch its data input to the pad input, so the registered output can capture the pad as a fast input register while the combinational output carries an unrelated function.

The whole cell runs on one system clock, `clk_i`. The clock source chosen by configuration (one of four global clocks, a per-cell product-term clock, or a shared product-term clock) is sampled on every `clk_i` edge. A rising edge of that source, seen between two consecutive samples, is a flop event. A high level of that source makes the latch transparent. A selectable clock enable qualifies both, so the clock itself is never gated.

A global reset with configurable active level and a per-cell product-term reset both force the registered output to 0. A per-cell product-term preset forces it to 1. Each force acts on the output at once and on the stored value at the next `clk_i` edge. A multiplexer picks the pad output enable.

Top module: `mc_macrocell`

## Requirements
- R1: `comb_o` equals `sop_i XOR cfg_xor_i` in the same cycle.
- R2: In flop mode (`cfg_latch_i`=0), the stored value takes D on a `clk_i` edge only when the enable is true and the selected clock source is high at that edge while it was low at the previous edge. Otherwise the stored value holds. `reg_o` shows the stored value.
- R3: In latch mode (`cfg_latch_i`=1), `reg_o` follows D in the same cycle while the selected clock source is high and the enable is true. The stored value takes D on each such `clk_i` edge and holds otherwise.
- R4: The clock source is set by `cfg_clk_sel_i`: 0..3 picks `gclk_i[0..3]`, 4 picks `pt_clk_i`, 5 picks `shr_clk_i`, and 6 or 7 picks a constant low, so the storage never updates.
- R5: The enable is set by `cfg_ce_sel_i`: 0 is always enabled, 1 picks `gce_i`, 2 picks `pt_ce_i`, and 3 is never enabled.
- R6: The global reset is active when `grst_i` equals `cfg_rst_pol_i`. While it is active, `reg_o` is 0 in the same cycle and the stored value is cleared at the next `clk_i` edge.
- R7: `pt_rst_i`=1 acts like the global reset. `pt_set_i`=1 forces `reg_o` to 1 and sets the stored value. Either reset wins over the preset.
- R8: With `cfg_pad_d_i`=1, D is `pad_i`, with no inversion. With `cfg_pad_d_i`=0, D is `sop_i XOR cfg_xor_i`. `comb_o` is unaffected either way.
- R9: `oe_o` is set by `cfg_oe_sel_i`: 0 picks `pt_oe_i`, 1..4 picks `gpt_oe_i[0..3]`, 5..6 picks `goe_i[0..1]`, and 7 gives 0.
- R10: While `rst_ni` is low, the stored value and the clock-edge history are 0. After release, a source that is already high counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_xor_i | input | 1 | Invert the sum-of-products |
| cfg_latch_i | input | 1 | 1 = latch, 0 = flip-flop |
| cfg_clk_sel_i | input | 3 | Clock source select |
| cfg_ce_sel_i | input | 2 | Clock enable select |
| cfg_rst_pol_i | input | 1 | Active level of grst_i |
| cfg_pad_d_i | input | 1 | Take D from pad_i |
| cfg_oe_sel_i | input | 3 | Output enable select |
| sop_i | input | 1 | Sum-of-products term |
| pad_i | input | 1 | Pad input |
| gclk_i | input | 4 | Global clocks |
| pt_clk_i | input | 1 | Per-cell product-term clock |
| shr_clk_i | input | 1 | Shared product-term clock |
| gce_i | input | 1 | Global clock enable |
| pt_ce_i | input | 1 | Product-term clock enable |
| grst_i | input | 1 | Global reset |
| pt_rst_i | input | 1 | Product-term reset |
| pt_set_i | input | 1 | Product-term preset |
| pt_oe_i | input | 1 | Per-cell product-term OE |
| gpt_oe_i | input | 4 | Global product-term OEs |
| goe_i | input | 2 | Global OE pins |
| comb_o | output | 1 | Combinational output |
| reg_o | output | 1 | Registered output |
| oe_o | output | 1 | Pad output enable |

## Verification
These outputs respond in the same cycle as their inputs:
- `comb_o` and `oe_o`;
- a transparent latch on `reg_o`;
- the reset and preset forces on `reg_o`.

A flop load appears on `reg_o` one `clk_i` edge after the edge that saw the rising clock source. The bench drives every input just after a falling edge and checks the outputs one time unit later, against a model holding the stored bit and the last sampled clock source. It then advances that model at the rising edge, using the inputs it just drove. A same-cycle result and a one-edge-delayed result are therefore each compared in the cycle where they are due. Thousands of cycles with configuration and inputs changing every cycle, plus an exhaustive output-enable sweep, cover every select code.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    CE_ON  = 2'd0,
    CE_GLB = 2'd1,
    CE_PT  = 2'd2,
    CE_OFF = 2'd3
  } ce_sel_e;
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int NUM_GCLK = 4,
  localparam int NSRC = NUM_GCLK + 2,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SELW-1:0]     sel_i,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                pt_clk_i,
  input  logic                shr_clk_i,
  output logic                lvl_o,
  output logic                rise_o
);
  logic [NSRC-1:0] src;
  logic            prev_q;

  assign src = {shr_clk_i, pt_clk_i, gclk_i};

  // codes past the last source select a constant low
  always_comb begin
    lvl_o = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_i == SELW'(i)) lvl_o = src[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;

  assign rise_o = lvl_o & ~prev_q;
endmodule

// File: rtl/mc_oe_sel.sv
module mc_oe_sel #(
  parameter int NUM_GPTOE = 4,
  parameter int NUM_GOE   = 2,
  localparam int NSRC = 1 + NUM_GPTOE + NUM_GOE,
  localparam int SELW = $clog2(NSRC + 1)
) (
  input  logic [SELW-1:0]      sel_i,
  input  logic                 pt_oe_i,
  input  logic [NUM_GPTOE-1:0] gpt_oe_i,
  input  logic [NUM_GOE-1:0]   goe_i,
  output logic                 oe_o
);
  logic [NSRC-1:0] src;

  assign src = {goe_i, gpt_oe_i, pt_oe_i};

  always_comb begin
    oe_o = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_i == SELW'(i)) oe_o = src[i];
  end
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_i,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic ce_i,
  input  logic d_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  logic st_q;
  logic open_w;
  logic upd_w;

  assign open_w = latch_i & lvl_i & ce_i;
  assign upd_w  = ce_i & (latch_i ? lvl_i : rise_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    st_q <= 1'b0;
    else if (clr_i) st_q <= 1'b0;
    else if (set_i) st_q <= 1'b1;
    else if (upd_w) st_q <= d_i;

  // forces reach the output at once; clear beats set
  always_comb begin
    if (clr_i)       q_o = 1'b0;
    else if (set_i)  q_o = 1'b1;
    else if (open_w) q_o = d_i;
    else             q_o = st_q;
  end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
  parameter int NUM_GCLK  = 4,
  parameter int NUM_GPTOE = 4,
  parameter int NUM_GOE   = 2
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     cfg_xor_i,
  input  logic                                     cfg_latch_i,
  input  logic [$clog2(NUM_GCLK+2)-1:0]            cfg_clk_sel_i,
  input  logic [1:0]                               cfg_ce_sel_i,
  input  logic                                     cfg_rst_pol_i,
  input  logic                                     cfg_pad_d_i,
  input  logic [$clog2(NUM_GPTOE+NUM_GOE+2)-1:0]   cfg_oe_sel_i,
  input  logic                                     sop_i,
  input  logic                                     pad_i,
  input  logic [NUM_GCLK-1:0]                      gclk_i,
  input  logic                                     pt_clk_i,
  input  logic                                     shr_clk_i,
  input  logic                                     gce_i,
  input  logic                                     pt_ce_i,
  input  logic                                     grst_i,
  input  logic                                     pt_rst_i,
  input  logic                                     pt_set_i,
  input  logic                                     pt_oe_i,
  input  logic [NUM_GPTOE-1:0]                     gpt_oe_i,
  input  logic [NUM_GOE-1:0]                       goe_i,
  output logic                                     comb_o,
  output logic                                     reg_o,
  output logic                                     oe_o
);
  import mc_pkg::*;

  localparam int CSW = $clog2(NUM_GCLK + 2);
  localparam int OSW = $clog2(NUM_GPTOE + NUM_GOE + 2);

  logic    lvl_w, rise_w, ce_w, d_w, clr_w;
  ce_sel_e ce_sel;

  assign comb_o = sop_i ^ cfg_xor_i;
  assign d_w    = cfg_pad_d_i ? pad_i : comb_o;
  assign clr_w  = (grst_i == cfg_rst_pol_i) | pt_rst_i;
  assign ce_sel = ce_sel_e'(cfg_ce_sel_i);

  always_comb begin
    unique case (ce_sel)
      CE_ON:   ce_w = 1'b1;
      CE_GLB:  ce_w = gce_i;
      CE_PT:   ce_w = pt_ce_i;
      default: ce_w = 1'b0;
    endcase
  end

  mc_clk_sel #(.NUM_GCLK(NUM_GCLK)) u_clk_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (cfg_clk_sel_i),
    .gclk_i    (gclk_i),
    .pt_clk_i  (pt_clk_i),
    .shr_clk_i (shr_clk_i),
    .lvl_o     (lvl_w),
    .rise_o    (rise_w)
  );

  mc_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (cfg_latch_i),
    .lvl_i   (lvl_w),
    .rise_i  (rise_w),
    .ce_i    (ce_w),
    .d_i     (d_w),
    .clr_i   (clr_w),
    .set_i   (pt_set_i),
    .q_o     (reg_o)
  );

  mc_oe_sel #(.NUM_GPTOE(NUM_GPTOE), .NUM_GOE(NUM_GOE)) u_oe_sel (
    .sel_i    (cfg_oe_sel_i),
    .pt_oe_i  (pt_oe_i),
    .gpt_oe_i (gpt_oe_i),
    .goe_i    (goe_i),
    .oe_o     (oe_o)
  );
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
  parameter int CSW = 3,
  parameter int OSW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_xor_i,
  input logic           cfg_latch_i,
  input logic [CSW-1:0] cfg_clk_sel_i,
  input logic [1:0]     cfg_ce_sel_i,
  input logic           cfg_rst_pol_i,
  input logic [OSW-1:0] cfg_oe_sel_i,
  input logic           sop_i,
  input logic           grst_i,
  input logic           pt_rst_i,
  input logic           pt_set_i,
  input logic [1:0]     goe_i,
  input logic           comb_o,
  input logic           reg_o,
  input logic           oe_o
);
  logic frc;
  assign frc = (grst_i == cfg_rst_pol_i) | pt_rst_i | pt_set_i;

  // R1
  inv_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_xor_i |-> (comb_o != sop_i));

  // R6
  glb_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grst_i == cfg_rst_pol_i) |-> !reg_o);

  // R7
  preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_set_i && !pt_rst_i && grst_i != cfg_rst_pol_i) |-> reg_o);

  // R5
  ce_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_latch_i && cfg_ce_sel_i == 2'd3 && !frc)
      |=> (frc || cfg_latch_i || $stable(reg_o)));

  // R4
  no_clk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_latch_i && cfg_clk_sel_i >= CSW'(6) && !frc)
      |=> (frc || cfg_latch_i || $stable(reg_o)));

  // R9
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_oe_sel_i == OSW'(7)) |-> !oe_o);

  // R9
  oe_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_oe_sel_i == OSW'(5)) |-> (oe_o == goe_i[0]));
endmodule

bind mc_macrocell mc_macrocell_chk #(.CSW(CSW), .OSW(OSW)) u_chk (.*);

// File: tb/tb_mc_macrocell.sv
module tb_mc_macrocell;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_xor_i, cfg_latch_i, cfg_rst_pol_i, cfg_pad_d_i;
  logic [2:0] cfg_clk_sel_i, cfg_oe_sel_i;
  logic [1:0] cfg_ce_sel_i;
  logic       sop_i, pad_i, pt_clk_i, shr_clk_i, gce_i, pt_ce_i;
  logic       grst_i, pt_rst_i, pt_set_i, pt_oe_i;
  logic [3:0] gclk_i, gpt_oe_i;
  logic [1:0] goe_i;
  logic       comb_o, reg_o, oe_o;

  int  n_chk = 0;
  int  n_fail = 0;
  logic m_st, m_prev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mc_macrocell dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_lvl();
    case (cfg_clk_sel_i)
      3'd0, 3'd1, 3'd2, 3'd3: return gclk_i[cfg_clk_sel_i[1:0]];
      3'd4: return pt_clk_i;
      3'd5: return shr_clk_i;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic m_ce();
    case (cfg_ce_sel_i)
      2'd0: return 1'b1;
      2'd1: return gce_i;
      2'd2: return pt_ce_i;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic m_oe();
    case (cfg_oe_sel_i)
      3'd0: return pt_oe_i;
      3'd1, 3'd2, 3'd3, 3'd4: return gpt_oe_i[cfg_oe_sel_i - 3'd1];
      3'd5: return goe_i[0];
      3'd6: return goe_i[1];
      default: return 1'b0;
    endcase
  endfunction

  // inputs are already driven (just after a falling edge)
  task automatic step();
    logic lvl, ce, d, clr, set, exp_r;
    string tag;
    lvl = m_lvl();
    ce  = m_ce();
    d   = cfg_pad_d_i ? pad_i : (sop_i ^ cfg_xor_i);
    clr = (grst_i == cfg_rst_pol_i) | pt_rst_i;
    set = pt_set_i & ~clr;
    if (clr) exp_r = 1'b0;
    else if (set) exp_r = 1'b1;
    else if (cfg_latch_i && lvl && ce) exp_r = d;
    else exp_r = m_st;
    if (clr) tag = (grst_i == cfg_rst_pol_i) ? "R6" : "R7";
    else if (set) tag = "R7";
    else if (cfg_latch_i) tag = "R3";
    else if (cfg_pad_d_i) tag = "R8";
    else if (cfg_clk_sel_i >= 3'd6) tag = "R4";
    else if (cfg_ce_sel_i != 2'd0) tag = "R5";
    else tag = "R2";
    #1;
    chk("R1", comb_o, sop_i ^ cfg_xor_i);
    chk(tag, reg_o, exp_r);
    chk("R9", oe_o, m_oe());
    @(posedge clk_i);
    if (clr) m_st = 1'b0;
    else if (set) m_st = 1'b1;
    else if (ce && (cfg_latch_i ? lvl : (lvl && !m_prev))) m_st = d;
    m_prev = lvl;
    @(negedge clk_i);
  endtask

  task automatic drive_all(input logic [31:0] a, input logic [31:0] b);
    {cfg_xor_i, cfg_latch_i, cfg_pad_d_i, cfg_rst_pol_i} = a[3:0];
    cfg_clk_sel_i = a[6:4];
    cfg_ce_sel_i  = a[8:7];
    cfg_oe_sel_i  = a[11:9];
    {sop_i, pad_i, pt_clk_i, shr_clk_i, gce_i, pt_ce_i} = a[17:12];
    gclk_i   = a[21:18];
    gpt_oe_i = a[25:22];
    goe_i    = a[27:26];
    pt_oe_i  = a[28];
    grst_i   = cfg_rst_pol_i ^ (b[2:0] != 3'd0);
    pt_rst_i = (b[5:3] == 3'd0);
    pt_set_i = (b[8:6] == 3'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    drive_all(32'h0, 32'h1ff);
    cfg_rst_pol_i = 1'b1; grst_i = 1'b0;
    cfg_oe_sel_i = 3'd7;
    m_st = 1'b0; m_prev = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R10", reg_o, 1'b0);
    chk("R9", oe_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10: a source already high right after reset loads as an edge
    cfg_clk_sel_i = 3'd0; gclk_i = 4'b0001; sop_i = 1'b1;
    step();
    gclk_i = 4'b0;
    step();

    // R9: every select code against every source pattern
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 128; p++) begin
        cfg_oe_sel_i = 3'(s);
        {goe_i, gpt_oe_i, pt_oe_i} = 7'(p);
        step();
      end

    for (int i = 0; i < 6000; i++) begin
      drive_all($urandom, $urandom);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule